// File: doc/BRIEF.md
# Microprogram Sequencer with Dual Next-Address Fields

This block is the control sequencer of a microprogrammed processor. It holds a control store of microinstruction words. Each word has a horizontal control field, a condition selector and two complete next-address fields. On every clock the sequencer presents the control field of the word at the current microaddress to the datapath. It then loads the next microaddress directly from one of the two address fields. The selected condition decides which field is used.

The condition may be a datapath status flag, a pending interrupt, the indirect bit of the instruction register, or an opcode dispatch. For a dispatch, the opcode is placed into the low bits of the second address. No incrementer and no address adder exist. The control store is built from a constant table inside the design. It holds the fetch, indirect, execute and interrupt microroutines.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the microaddress becomes 0 on that edge. Word 0 is the first fetch word, so `upc` reads 0 and `ctrl` reads 16'h0001.
- R2: One microinstruction executes per clock. `ctrl` always equals the control field of the word at the current `upc`, and `upc` loads a new value on every rising edge that is not in reset.
- R3: The selector codes are: 0 is always false, 1 is `zero_flag`, 2 is `carry_flag`, 3 is `irq_pending`, 4 is `ir_indirect`, and 7 is dispatch (always true). Codes 5 and 6 are always false. When the condition is true the next address is address 2; otherwise it is address 1.
- R4: For a dispatch, the next address is address 2 with its low 3 bits replaced by `ir_opcode`. The dispatch word 6 has address 2 = 16, so it goes to 16 + opcode.
- R5: The fetch routine runs through three words:
  - Word 0 has ctrl 16'h0001 (bit 0, address register from program counter).
  - Word 1 has ctrl 16'h0006 (bit 1, memory read; bit 2, program counter increment).
  - Word 2 has ctrl 16'h0008 (bit 3, instruction register load) and selector 4. It goes to 3 when `ir_indirect` is 1, and to 6 otherwise.
- R6: The indirect routine runs through three words and then goes to 6:
  - Word 3 has ctrl 16'h0010 (bit 4, address register from instruction address).
  - Word 4 has ctrl 16'h0002.
  - Word 5 has ctrl 16'h0020 (bit 5, instruction address from buffer).
- R7: Opcode 0 (add) runs words 16, 24 and 25. Their ctrl values are 16'h0010, 16'h0002 and 16'h0040 (bit 6, accumulator add).
- R8: Opcode 1 runs word 17, which tests `zero_flag`. Opcode 2 runs word 18, which tests `carry_flag`. Both have ctrl 0. Each goes to 27 when its flag is 1 and to 26 otherwise. Word 27 has ctrl 16'h0080 (bit 7, program counter from instruction address) and goes to 26.
- R9: Words 25 and 26 test `irq_pending`. They go to 8 when it is 1 and to 0 otherwise. Word 26 has ctrl 0.
- R10: The interrupt routine runs through three words and then returns to 0:
  - Word 8 has ctrl 16'h0100 (bit 8, buffer from program counter).
  - Word 9 has ctrl 16'h0600 (bit 9, save address; bit 10, load routine vector).
  - Word 10 has ctrl 16'h0800 (bit 11, memory write).
- R11: Every other word, including the targets of opcodes 3 to 7, has ctrl 0 and returns to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_flag | input | 1 | Datapath zero status |
| carry_flag | input | 1 | Datapath carry status |
| irq_pending | input | 1 | Interrupt request pending |
| ir_indirect | input | 1 | Indirect bit of the instruction register |
| ir_opcode | input | 3 | Opcode field of the instruction register |
| upc | output | 6 | Current microaddress |
| ctrl | output | 16 | Control field of the current microinstruction |

## Verification
The sequencer is run through complete instruction cycles, and the bench compares the microaddress and control word on every cycle. The add opcode is tried with and without the indirect bit, which shows whether the fetch-end test reads the right input. It is also tried with and without a pending interrupt, which separates the interrupt exit from the return to fetch. The two jump opcodes are tried with each flag set alone, so that a mixed-up zero and carry select gives a wrong path. An unused opcode checks the dispatch arithmetic and the default words. A reset in the middle of a routine checks that the sequencer returns to fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int ADDR_W = 6;
    localparam int CTRL_W = 16;
    localparam int SEL_W  = 3;
    localparam int OPC_W  = 3;
    localparam int DEPTH  = 1 << ADDR_W;

    // condition selector codes
    localparam logic [SEL_W-1:0] SEL_NEVER = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ZERO  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CARRY = 3'd2;
    localparam logic [SEL_W-1:0] SEL_IRQ   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_INDIR = 3'd4;
    localparam logic [SEL_W-1:0] SEL_DISP  = 3'd7;

    // control bit positions
    localparam int CB_MAR_PC  = 0;
    localparam int CB_MEM_RD  = 1;
    localparam int CB_PC_INC  = 2;
    localparam int CB_IR_LD   = 3;
    localparam int CB_MAR_IRA = 4;
    localparam int CB_IRA_MBR = 5;
    localparam int CB_ACC_ADD = 6;
    localparam int CB_PC_IRA  = 7;
    localparam int CB_MBR_PC  = 8;
    localparam int CB_MAR_SV  = 9;
    localparam int CB_PC_VEC  = 10;
    localparam int CB_MEM_WR  = 11;

    // microroutine entry points
    localparam int UA_FETCH  = 0;
    localparam int UA_IND    = 3;
    localparam int UA_DISP   = 6;
    localparam int UA_INTR   = 8;
    localparam int UA_EXEC   = 16;
    localparam int UA_ADD2   = 24;
    localparam int UA_IRQCHK = 26;
    localparam int UA_JUMP   = 27;

    typedef logic [ADDR_W-1:0] uaddr_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [SEL_W-1:0]   sel;
        uaddr_t             alt_a;   // address 1
        uaddr_t             alt_b;   // address 2
    } uword_t;

    typedef struct packed {
        logic zero;
        logic carry;
        logic irq;
        logic indir;
    } status_t;

    function automatic ctrl_t cbit(input int n);
        ctrl_t v;
        v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    function automatic uword_t mkw(input ctrl_t c, input logic [SEL_W-1:0] s,
                                   input int a1, input int a2);
        uword_t w;
        w.ctrl  = c;
        w.sel   = s;
        w.alt_a = uaddr_t'(a1);
        w.alt_b = uaddr_t'(a2);
        return w;
    endfunction

    // constant microprogram
    function automatic uword_t store_word(input int a);
        case (a)
            0:  return mkw(cbit(CB_MAR_PC), SEL_NEVER, 1, 0);
            1:  return mkw(cbit(CB_MEM_RD) | cbit(CB_PC_INC), SEL_NEVER, 2, 0);
            2:  return mkw(cbit(CB_IR_LD), SEL_INDIR, UA_DISP, UA_IND);
            3:  return mkw(cbit(CB_MAR_IRA), SEL_NEVER, 4, 0);
            4:  return mkw(cbit(CB_MEM_RD), SEL_NEVER, 5, 0);
            5:  return mkw(cbit(CB_IRA_MBR), SEL_NEVER, UA_DISP, 0);
            6:  return mkw('0, SEL_DISP, 0, UA_EXEC);
            8:  return mkw(cbit(CB_MBR_PC), SEL_NEVER, 9, 0);
            9:  return mkw(cbit(CB_MAR_SV) | cbit(CB_PC_VEC), SEL_NEVER, 10, 0);
            10: return mkw(cbit(CB_MEM_WR), SEL_NEVER, UA_FETCH, 0);
            16: return mkw(cbit(CB_MAR_IRA), SEL_NEVER, UA_ADD2, 0);
            17: return mkw('0, SEL_ZERO, UA_IRQCHK, UA_JUMP);
            18: return mkw('0, SEL_CARRY, UA_IRQCHK, UA_JUMP);
            24: return mkw(cbit(CB_MEM_RD), SEL_NEVER, 25, 0);
            25: return mkw(cbit(CB_ACC_ADD), SEL_IRQ, UA_FETCH, UA_INTR);
            26: return mkw('0, SEL_IRQ, UA_FETCH, UA_INTR);
            27: return mkw(cbit(CB_PC_IRA), SEL_NEVER, UA_IRQCHK, 0);
            default: return mkw('0, SEL_NEVER, UA_FETCH, UA_FETCH);
        endcase
    endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);
    uword_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = store_word(i);
    end

    assign word = rom[addr];
endmodule

// File: rtl/useq_cond.sv
module useq_cond
    import useq_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  status_t          st,
    output logic             take
);
    always_comb begin
        case (sel)
            SEL_ZERO:  take = st.zero;
            SEL_CARRY: take = st.carry;
            SEL_IRQ:   take = st.irq;
            SEL_INDIR: take = st.indir;
            SEL_DISP:  take = 1'b1;
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  uword_t             word,
    input  logic               take,
    input  logic [OPC_W-1:0]   opcode,
    output uaddr_t             nxt
);
    uaddr_t disp_addr;

    assign disp_addr = {word.alt_b[ADDR_W-1:OPC_W], opcode};

    always_comb begin
        if (!take)
            nxt = word.alt_a;
        else if (word.sel == SEL_DISP)
            nxt = disp_addr;
        else
            nxt = word.alt_b;
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                zero_flag,
    input  logic                carry_flag,
    input  logic                irq_pending,
    input  logic                ir_indirect,
    input  logic [OPC_W-1:0]    ir_opcode,
    output logic [ADDR_W-1:0]   upc,
    output logic [CTRL_W-1:0]   ctrl
);
    uaddr_t  upc_q;
    uaddr_t  upc_d;
    uword_t  cur;
    status_t st;
    logic    take;

    assign st = '{zero: zero_flag, carry: carry_flag, irq: irq_pending, indir: ir_indirect};

    useq_store u_store (.addr(upc_q), .word(cur));
    useq_cond  u_cond  (.sel(cur.sel), .st(st), .take(take));
    useq_next  u_next  (.word(cur), .take(take), .opcode(ir_opcode), .nxt(upc_d));

    always_ff @(posedge clk) begin
        if (rst)
            upc_q <= '0;
        else
            upc_q <= upc_d;
    end

    assign upc  = upc_q;
    assign ctrl = cur.ctrl;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               zero_flag,
    input logic               irq_pending,
    input logic [OPC_W-1:0]   ir_opcode,
    input uaddr_t             upc,
    input uword_t             cur
);
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> upc == '0);

    a_r3_never_takes_a1: assert property (@(posedge clk) disable iff (rst)
        (cur.sel == SEL_NEVER || cur.sel == 3'd5 || cur.sel == 3'd6) |=> upc == $past(cur.alt_a));

    a_r3_zero_select: assert property (@(posedge clk) disable iff (rst)
        (cur.sel == SEL_ZERO) |=> upc == ($past(zero_flag) ? $past(cur.alt_b) : $past(cur.alt_a)));

    a_r9_irq_select: assert property (@(posedge clk) disable iff (rst)
        (cur.sel == SEL_IRQ && irq_pending) |=> upc == UA_INTR);

    a_r4_dispatch: assert property (@(posedge clk) disable iff (rst)
        (cur.sel == SEL_DISP) |=> (upc[OPC_W-1:0] == $past(ir_opcode)
                                   && upc[ADDR_W-1:OPC_W] == $past(cur.alt_b[ADDR_W-1:OPC_W])));
endmodule

bind useq_top useq_chk i_chk (
    .clk(clk), .rst(rst), .zero_flag(zero_flag), .irq_pending(irq_pending),
    .ir_opcode(ir_opcode), .upc(upc_q), .cur(cur)
);

// File: tb/test_useq_top.sv
module test_useq_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic zero_flag = 0, carry_flag = 0, irq_pending = 0, ir_indirect = 0;
    logic [2:0]  ir_opcode = '0;
    logic [5:0]  upc;
    logic [15:0] ctrl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct { logic [5:0] a; string req; } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    useq_top i_useq_top (.*);

    // control field per address, taken from the requirements
    function automatic logic [15:0] exp_ctrl(input logic [5:0] a);
        case (a)
            0: return 16'h0001;  1: return 16'h0006;  2: return 16'h0008;
            3: return 16'h0010;  4: return 16'h0002;  5: return 16'h0020;
            8: return 16'h0100;  9: return 16'h0600;  10: return 16'h0800;
            16: return 16'h0010; 24: return 16'h0002; 25: return 16'h0040;
            27: return 16'h0080;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string req, input logic [5:0] ea);
        n_chk++;
        if (upc !== ea || ctrl !== exp_ctrl(ea)) begin
            n_bad++;
            $display("FAIL %s: upc=%0d ctrl=%h expected upc=%0d ctrl=%h",
                     req, upc, ctrl, ea, exp_ctrl(ea));
        end
    endtask

    // monitor: one expected item per cycle
    always @(negedge clk) begin
        #1;
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, e.a);
        end
    end

    task automatic run(input string req, input logic z, input logic c, input logic irq,
                       input logic ind, input logic [2:0] op, input int seq[$]);
        @(negedge clk);
        rst = 1'b1;
        {zero_flag, carry_flag, irq_pending, ir_indirect, ir_opcode} = {z, c, irq, ind, op};
        @(negedge clk);
        rst = 1'b0;
        foreach (seq[i]) q.push_back('{a: 6'(seq[i]), req: req});
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #1;
        check("R1 reset state", 6'd0);

        // R5 R7 R2: direct add, no interrupt
        run("R7 add direct",        0, 0, 0, 0, 3'd0, '{0,1,2,6,16,24,25,0,1});
        // R6: indirect add
        run("R6 add indirect",      0, 0, 0, 1, 3'd0, '{0,1,2,3,4,5,6,16,24,25,0});
        // R9 R10: interrupt after add
        run("R10 add then irq",     0, 0, 1, 0, 3'd0, '{0,1,2,6,16,24,25,8,9,10,0});
        // R8: jump on zero, taken and not taken, carry alone must not matter
        run("R8 jz taken",          1, 0, 0, 0, 3'd1, '{0,1,2,6,17,27,26,0});
        run("R8 jz not taken",      0, 1, 0, 0, 3'd1, '{0,1,2,6,17,26,0});
        run("R8 jc taken",          0, 1, 0, 0, 3'd2, '{0,1,2,6,18,27,26,0});
        run("R8 jc not taken",      1, 0, 0, 0, 3'd2, '{0,1,2,6,18,26,0});
        // R9: jump then interrupt check
        run("R9 jz then irq",       1, 0, 1, 0, 3'd1, '{0,1,2,6,17,27,26,8,9,10,0});
        // R4 R11: unused opcodes land in default words
        run("R4 R11 opcode 5",      0, 0, 0, 0, 3'd5, '{0,1,2,6,21,0,1});
        run("R4 R11 opcode 7 ind",  1, 1, 1, 1, 3'd7, '{0,1,2,3,4,5,6,23,0});
        // R3: interrupt pending is ignored outside selector 3 words
        run("R3 irq ignored early", 0, 0, 1, 0, 3'd3, '{0,1,2,6,19,0});

        // R1: reset in the middle of a routine
        @(negedge clk);
        rst = 1'b1;
        {zero_flag, carry_flag, irq_pending, ir_indirect, ir_opcode} = 7'b0000000;
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check("R2 mid routine", 6'd16);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R1 reset mid routine", 6'd0);
        rst = 1'b0;

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule